// File: doc/BRIEF.md
# DMA Line-Split Request Sequencer

This block takes one DMA transfer at a time, given as a byte start address, a byte count and a read/write flag (plus a source buffer for writes), and turns it into a chain of memory transactions that never cross a cache-line boundary. The first transaction may begin mid-line. It carries that in-line offset and a length clipped to the end of the line. Every transaction after it is line-aligned, carries offset zero and covers at most one full line.

Only one transaction is outstanding at any time. The sequencer waits for the answer before it issues the next piece: a data response for reads, an acknowledge for writes. Responses are matched by line address. For reads, each response returns a whole line, and the sequencer copies the bytes it asked for into a result buffer at the right position. When the last piece has been answered, the block pulses done and is ready for a new transfer.

Top module: `dma_line_sequencer`

## Requirements
- R1: Only one transfer is in flight at a time. A request while busy, or a request whose length exceeds the buffer size (64 bytes by default), gets a one-cycle `req_reject_o` pulse on the following cycle and changes nothing else.
- R2: A zero-length request raises `done_o` for one cycle on the following cycle and issues no transaction.
- R3: The first transaction's physical address is the start address, and its offset field is the start address's low log2(line size) bits.
- R4: The first transaction's length is the request length when offset + length is at most the line size. Otherwise it is line size − offset.
- R5: For a write, the first transaction's data holds request byte k at line byte offset+k, and every other byte of the line is zero.
- R6: Each later transaction has physical address = start + bytes completed. That address is line-aligned, its offset field is 0, and its length is min(remaining bytes, line size).
- R7: For a later write transaction, line byte k holds source buffer byte (bytes completed + k) for k < length, and every other byte is zero.
- R8: Every transaction's line address is its physical address with the low offset bits cleared. A response whose line address differs from the outstanding one raises `rsp_error_o` on the next cycle and is otherwise ignored.
- R9: For a read, the result buffer holds byte i of the transfer at buffer byte i. Each piece is taken from its response line starting at the piece's offset (the start offset for the first piece, 0 afterwards). Buffer bytes at or beyond the length are zero.
- R10: A data response (`rsp_is_data_i`=1) while a write is outstanding, an acknowledge (`rsp_is_data_i`=0) while a read is outstanding, or any response while idle raises `rsp_error_o` on the next cycle and is otherwise ignored.
- R11: `txn_valid_o` pulses for one cycle, one cycle after the request is accepted or after a matching response. No new transaction appears without one of these.
- R12: One cycle after the response that completes the last byte, `done_o` is high for exactly one cycle and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Transfer request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte start address |
| req_len_i | input | 7 | Byte count |
| req_wdata_i | input | 512 | Source bytes for a write, byte i at bits [8i+7:8i] |
| req_reject_o | output | 1 | Request refused (busy or too long) |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_buf_o | output | 512 | Assembled read bytes |
| txn_valid_o | output | 1 | One-cycle transaction issue strobe |
| txn_write_o | output | 1 | Transaction type |
| txn_paddr_o | output | 32 | Transaction physical address |
| txn_line_o | output | 32 | Transaction line address |
| txn_off_o | output | 4 | Byte offset within the line |
| txn_len_o | output | 5 | Byte count of the transaction |
| txn_data_o | output | 128 | Line-wide write data (zero for reads) |
| rsp_valid_i | input | 1 | Response strobe |
| rsp_is_data_i | input | 1 | 1 = data response, 0 = acknowledge |
| rsp_line_i | input | 32 | Line address of the response |
| rsp_data_i | input | 128 | Whole-line data of a data response |
| rsp_error_o | output | 1 | Response refused (mismatch or wrong kind) |

## Verification
Transfers are run with several start positions and lengths. A mid-line start that spans three lines separates the clipped first piece from the aligned later ones. A piece ending exactly at the line boundary tests the "at most" side of the first-length rule, and a piece that fits strictly inside a line tests the other side. Aligned full-line runs, a one-byte read in the last byte of a line, and a zero-length request cover the extremes of the length arithmetic. Faults are injected while a transfer waits: a competing request, a response for the wrong line, and responses of the wrong kind. Each fault must be refused without disturbing the transaction sequence the scoreboard expects.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 7,
    parameter int LINE_BYTES = 16
) (
    input  logic [ADDR_W-1:0]                    start_i,
    input  logic [LEN_W-1:0]                     total_i,
    input  logic [LEN_W-1:0]                     done_bytes_i,
    input  logic                                 first_i,
    output logic [ADDR_W-1:0]                    paddr_o,
    output logic [ADDR_W-1:0]                    line_o,
    output logic [$clog2(LINE_BYTES)-1:0]        off_o,
    output logic [$clog2(LINE_BYTES+1)-1:0]      clen_o
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int CLEN_W = $clog2(LINE_BYTES+1);
    localparam int SW     = LEN_W + 2;

    logic [SW-1:0] off_x, total_x, done_x, sum_x, rem_x, line_x;

    always_comb begin
        paddr_o = start_i + ADDR_W'(done_bytes_i);
        line_o  = paddr_o & ~ADDR_W'(LINE_BYTES - 1);
        off_o   = first_i ? paddr_o[OFF_W-1:0] : '0;
        off_x   = SW'(off_o);
        total_x = SW'(total_i);
        done_x  = SW'(done_bytes_i);
        line_x  = SW'(LINE_BYTES);
        sum_x   = off_x + total_x;
        rem_x   = total_x - done_x;
        if (first_i) begin
            clen_o = (sum_x <= line_x) ? CLEN_W'(total_x) : CLEN_W'(line_x - off_x);
        end else begin
            clen_o = (rem_x < line_x) ? CLEN_W'(rem_x) : CLEN_W'(line_x);
        end
    end

endmodule

// File: rtl/dma_wr_pack.sv
module dma_wr_pack #(
    parameter int BUF_BYTES  = 64,
    parameter int LINE_BYTES = 16,
    parameter int LEN_W      = 7
) (
    input  logic [BUF_BYTES*8-1:0]               src_buf_i,
    input  logic [LEN_W-1:0]                     base_i,
    input  logic [$clog2(LINE_BYTES)-1:0]        off_i,
    input  logic [$clog2(LINE_BYTES+1)-1:0]      clen_i,
    output logic [LINE_BYTES*8-1:0]              line_o
);
    always_comb begin
        int src;
        line_o = '0;
        for (int j = 0; j < LINE_BYTES; j++) begin
            src = int'(base_i) + j - int'(off_i);
            if ((j >= int'(off_i)) && (j < int'(off_i) + int'(clen_i)) &&
                (src >= 0) && (src < BUF_BYTES)) begin
                line_o[j*8 +: 8] = src_buf_i[src*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/dma_rd_merge.sv
module dma_rd_merge #(
    parameter int BUF_BYTES  = 64,
    parameter int LINE_BYTES = 16,
    parameter int LEN_W      = 7
) (
    input  logic [BUF_BYTES*8-1:0]               cur_buf_i,
    input  logic [LINE_BYTES*8-1:0]              line_i,
    input  logic [LEN_W-1:0]                     base_i,
    input  logic [$clog2(LINE_BYTES)-1:0]        off_i,
    input  logic [LEN_W-1:0]                     count_i,
    output logic [BUF_BYTES*8-1:0]               new_buf_o
);
    always_comb begin
        int src;
        new_buf_o = cur_buf_i;
        for (int i = 0; i < BUF_BYTES; i++) begin
            src = int'(off_i) + i - int'(base_i);
            if ((i >= int'(base_i)) && (i < int'(base_i) + int'(count_i)) &&
                (src >= 0) && (src < LINE_BYTES)) begin
                new_buf_o[i*8 +: 8] = line_i[src*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/dma_line_sequencer.sv
module dma_line_sequencer
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int BUF_BYTES  = 64
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid_i,
    input  logic                                  req_write_i,
    input  logic [ADDR_W-1:0]                     req_addr_i,
    input  logic [$clog2(BUF_BYTES+1)-1:0]        req_len_i,
    input  logic [BUF_BYTES*8-1:0]                req_wdata_i,
    output logic                                  req_reject_o,
    output logic                                  busy_o,
    output logic                                  done_o,
    output logic [BUF_BYTES*8-1:0]                rd_buf_o,
    output logic                                  txn_valid_o,
    output logic                                  txn_write_o,
    output logic [ADDR_W-1:0]                     txn_paddr_o,
    output logic [ADDR_W-1:0]                     txn_line_o,
    output logic [$clog2(LINE_BYTES)-1:0]         txn_off_o,
    output logic [$clog2(LINE_BYTES+1)-1:0]       txn_len_o,
    output logic [LINE_BYTES*8-1:0]               txn_data_o,
    input  logic                                  rsp_valid_i,
    input  logic                                  rsp_is_data_i,
    input  logic [ADDR_W-1:0]                     rsp_line_i,
    input  logic [LINE_BYTES*8-1:0]               rsp_data_i,
    output logic                                  rsp_error_o
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int CLEN_W = $clog2(LINE_BYTES+1);
    localparam int LEN_W  = $clog2(BUF_BYTES+1);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BUF_W  = BUF_BYTES * 8;

    typedef struct packed {
        seq_state_e         st;
        logic               wr;
        logic [ADDR_W-1:0]  start;
        logic [LEN_W-1:0]   total;
        logic [LEN_W-1:0]   issued;
        logic [LEN_W-1:0]   completed;
        logic [BUF_W-1:0]   wbuf;
        logic [BUF_W-1:0]   rbuf;
        logic               txn_valid;
        logic [ADDR_W-1:0]  paddr;
        logic [ADDR_W-1:0]  line;
        logic [OFF_W-1:0]   off;
        logic [CLEN_W-1:0]  clen;
        logic [LINE_W-1:0]  tdata;
        logic               done;
        logic               reject;
        logic               rsp_err;
    } seq_t;

    seq_t seq_d, seq_q;

    // chunk calculator inputs, selected by state
    logic [ADDR_W-1:0] c_start;
    logic [LEN_W-1:0]  c_total, c_done;
    logic              c_first;
    logic [BUF_W-1:0]  p_buf;

    logic [ADDR_W-1:0] c_paddr, c_line;
    logic [OFF_W-1:0]  c_off;
    logic [CLEN_W-1:0] c_clen;
    logic [LINE_W-1:0] p_line;
    logic [BUF_W-1:0]  m_buf;
    logic              rsp_match;

    always_comb begin
        if (seq_q.st == SEQ_IDLE) begin
            c_start = req_addr_i;
            c_total = req_len_i;
            c_done  = '0;
            c_first = 1'b1;
            p_buf   = req_wdata_i;
        end else begin
            c_start = seq_q.start;
            c_total = seq_q.total;
            c_done  = seq_q.issued;
            c_first = 1'b0;
            p_buf   = seq_q.wbuf;
        end
    end

    dma_chunk_calc #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .LINE_BYTES (LINE_BYTES)
    ) i_calc (
        .start_i      (c_start),
        .total_i      (c_total),
        .done_bytes_i (c_done),
        .first_i      (c_first),
        .paddr_o      (c_paddr),
        .line_o       (c_line),
        .off_o        (c_off),
        .clen_o       (c_clen)
    );

    dma_wr_pack #(
        .BUF_BYTES  (BUF_BYTES),
        .LINE_BYTES (LINE_BYTES),
        .LEN_W      (LEN_W)
    ) i_pack (
        .src_buf_i (p_buf),
        .base_i    (c_done),
        .off_i     (c_off),
        .clen_i    (c_clen),
        .line_o    (p_line)
    );

    dma_rd_merge #(
        .BUF_BYTES  (BUF_BYTES),
        .LINE_BYTES (LINE_BYTES),
        .LEN_W      (LEN_W)
    ) i_merge (
        .cur_buf_i (seq_q.rbuf),
        .line_i    (rsp_data_i),
        .base_i    (seq_q.completed),
        .off_i     (seq_q.off),
        .count_i   (seq_q.issued - seq_q.completed),
        .new_buf_o (m_buf)
    );

    always_comb begin
        seq_d           = seq_q;
        seq_d.txn_valid = 1'b0;
        seq_d.done      = 1'b0;
        seq_d.reject    = 1'b0;
        seq_d.rsp_err   = 1'b0;
        rsp_match = (rsp_line_i == seq_q.line) && (rsp_is_data_i == !seq_q.wr);

        case (seq_q.st)
            SEQ_IDLE: begin
                if (rsp_valid_i) begin
                    seq_d.rsp_err = 1'b1;
                end
                if (req_valid_i) begin
                    if (req_len_i > LEN_W'(BUF_BYTES)) begin
                        seq_d.reject = 1'b1;
                    end else begin
                        seq_d.wr        = req_write_i;
                        seq_d.start     = req_addr_i;
                        seq_d.total     = req_len_i;
                        seq_d.wbuf      = req_wdata_i;
                        seq_d.rbuf      = '0;
                        seq_d.completed = '0;
                        seq_d.issued    = '0;
                        if (req_len_i == '0) begin
                            seq_d.done = 1'b1;
                        end else begin
                            seq_d.txn_valid = 1'b1;
                            seq_d.paddr     = c_paddr;
                            seq_d.line      = c_line;
                            seq_d.off       = c_off;
                            seq_d.clen      = c_clen;
                            seq_d.tdata     = req_write_i ? p_line : '0;
                            seq_d.issued    = LEN_W'(c_clen);
                            seq_d.st        = SEQ_WAIT;
                        end
                    end
                end
            end
            SEQ_WAIT: begin
                if (req_valid_i) begin
                    seq_d.reject = 1'b1;
                end
                if (rsp_valid_i) begin
                    if (!rsp_match) begin
                        seq_d.rsp_err = 1'b1;
                    end else begin
                        if (!seq_q.wr) begin
                            seq_d.rbuf = m_buf;
                        end
                        seq_d.completed = seq_q.issued;
                        if (seq_q.issued == seq_q.total) begin
                            seq_d.done = 1'b1;
                            seq_d.st   = SEQ_IDLE;
                        end else begin
                            seq_d.txn_valid = 1'b1;
                            seq_d.paddr     = c_paddr;
                            seq_d.line      = c_line;
                            seq_d.off       = c_off;
                            seq_d.clen      = c_clen;
                            seq_d.tdata     = seq_q.wr ? p_line : '0;
                            seq_d.issued    = seq_q.issued + LEN_W'(c_clen);
                        end
                    end
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_reject_o = seq_q.reject;
    assign busy_o       = (seq_q.st == SEQ_WAIT);
    assign done_o       = seq_q.done;
    assign rd_buf_o     = seq_q.rbuf;
    assign txn_valid_o  = seq_q.txn_valid;
    assign txn_write_o  = seq_q.wr;
    assign txn_paddr_o  = seq_q.paddr;
    assign txn_line_o   = seq_q.line;
    assign txn_off_o    = seq_q.off;
    assign txn_len_o    = seq_q.clen;
    assign txn_data_o   = seq_q.tdata;
    assign rsp_error_o  = seq_q.rsp_err;

    // R1
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject_o |-> $past(req_valid_i));

    // R4
    chunk_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid_o |-> (txn_len_o != '0) &&
                        ((int'(txn_off_o) + int'(txn_len_o)) <= LINE_BYTES));

    // R6
    later_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid_o && $past(busy_o)) |-> (txn_off_o == '0) &&
                                           (txn_paddr_o[OFF_W-1:0] == '0));

    // R8
    line_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid_o |-> (txn_line_o[OFF_W-1:0] == '0) &&
                        (txn_line_o[ADDR_W-1:OFF_W] == txn_paddr_o[ADDR_W-1:OFF_W]));

    // R10
    rsp_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error_o |-> $past(rsp_valid_i));

    // R11
    txn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid_o |-> ($past(req_valid_i) || $past(rsp_valid_i)));

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !txn_valid_o);

endmodule

// File: tb/test_dma_line_sequencer.sv
module test_dma_line_sequencer;
    localparam int ADDR_W = 32;
    localparam int LINE_B = 16;
    localparam int BUF_B  = 64;
    localparam int OFF_W  = $clog2(LINE_B);
    localparam int CLEN_W = $clog2(LINE_B+1);
    localparam int LEN_W  = $clog2(BUF_B+1);

    typedef struct {
        bit                  w;
        int                  paddr;
        int                  line;
        int                  off;
        int                  len;
        logic [LINE_B*8-1:0] data;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [BUF_B*8-1:0] req_wdata = '0;
    logic req_reject, busy, done, txn_valid, txn_write, rsp_error;
    logic [BUF_B*8-1:0] rd_buf;
    logic [ADDR_W-1:0] txn_paddr, txn_line;
    logic [OFF_W-1:0] txn_off;
    logic [CLEN_W-1:0] txn_len;
    logic [LINE_B*8-1:0] txn_data;
    logic rsp_valid = 1'b0, rsp_is_data = 1'b0;
    logic [ADDR_W-1:0] rsp_line = '0;
    logic [LINE_B*8-1:0] rsp_data = '0;

    int nchk = 0;
    int nfail = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    dma_line_sequencer #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_B), .BUF_BYTES(BUF_B)) i_dma_line_sequencer (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
        .req_len_i(req_len), .req_wdata_i(req_wdata), .req_reject_o(req_reject),
        .busy_o(busy), .done_o(done), .rd_buf_o(rd_buf),
        .txn_valid_o(txn_valid), .txn_write_o(txn_write), .txn_paddr_o(txn_paddr),
        .txn_line_o(txn_line), .txn_off_o(txn_off), .txn_len_o(txn_len),
        .txn_data_o(txn_data),
        .rsp_valid_i(rsp_valid), .rsp_is_data_i(rsp_is_data), .rsp_line_i(rsp_line),
        .rsp_data_i(rsp_data), .rsp_error_o(rsp_error)
    );

    function automatic logic [7:0] mem_byte(int a);
        return 8'((a * 37 + 11) ^ (a >>> 8));
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compares every issued transaction against the scoreboard
    always @(negedge clk) begin
        if (rst_n && txn_valid) begin
            nchk++;
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL R11: actual unexpected transaction at %0h expected none", txn_paddr);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (txn_write !== e.w || txn_paddr !== ADDR_W'(e.paddr) ||
                    txn_line !== ADDR_W'(e.line) || txn_off !== OFF_W'(e.off) ||
                    txn_len !== CLEN_W'(e.len) || txn_data !== e.data) begin
                    nfail++;
                    $display("FAIL R3/R4/R5/R6/R7/R8: actual w%0d a%0h l%0h o%0d n%0d d%h expected w%0d a%0h l%0h o%0d n%0d d%h",
                             txn_write, txn_paddr, txn_line, txn_off, txn_len, txn_data,
                             e.w, e.paddr, e.line, e.off, e.len, e.data);
                end
            end
        end
    end

    // inj: 0 none, 1 competing request, 2 wrong line, 3 wrong response kind
    task automatic do_req(bit w, int addr, int len, int inj);
        logic [BUF_B*8-1:0] wb;
        logic [BUF_B*8-1:0] exp_rd;
        int pos, a, nexp;
        wb = '0;
        exp_rd = '0;
        for (int i = 0; i < BUF_B; i++) wb[i*8 +: 8] = 8'(i * 29 + addr);
        for (int i = 0; i < len; i++) exp_rd[i*8 +: 8] = mem_byte(addr + i);
        pos = 0;
        a = addr;
        nexp = 0;
        while (pos < len) begin
            exp_t e;
            int o, n;
            o = a % LINE_B;
            n = LINE_B - o;
            if (len - pos < n) n = len - pos;
            e.w = w; e.paddr = a; e.line = a - o; e.off = o; e.len = n;
            e.data = '0;
            if (w) for (int j = o; j < o + n; j++) e.data[j*8 +: 8] = wb[(pos + j - o)*8 +: 8];
            exp_q.push_back(e);
            nexp++;
            pos += n;
            a += n;
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = ADDR_W'(addr);
        req_len = LEN_W'(len); req_wdata = wb;
        @(negedge clk);
        req_valid = 1'b0;
        if (nexp == 0) begin
            chk("R2 done after zero length", longint'(done), 1);
            chk("R2 no transaction", longint'(txn_valid), 0);
            @(negedge clk);
            chk("R2 done one cycle", longint'(done), 0);
            return;
        end
        for (int k = 0; k < nexp; k++) begin
            logic [ADDR_W-1:0] ln;
            chk("R11 transaction issued", longint'(txn_valid), 1);
            ln = txn_line;
            @(negedge clk);
            chk("R11 no issue without response", longint'(txn_valid), 0);
            if (k == 0 && inj == 1) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h9999; req_len = 7'd5;
                @(negedge clk);
                req_valid = 1'b0;
                chk("R1 reject while busy", longint'(req_reject), 1);
                chk("R1 busy kept", longint'(busy), 1);
            end else if (k == 0 && inj == 2) begin
                rsp_valid = 1'b1; rsp_is_data = !w; rsp_line = ln + LINE_B;
                @(negedge clk);
                rsp_valid = 1'b0;
                chk("R8 wrong line error", longint'(rsp_error), 1);
                chk("R8 wrong line ignored", longint'(txn_valid), 0);
            end else if (k == 0 && inj == 3) begin
                rsp_valid = 1'b1; rsp_is_data = w; rsp_line = ln;
                @(negedge clk);
                rsp_valid = 1'b0;
                chk("R10 wrong kind error", longint'(rsp_error), 1);
                chk("R10 wrong kind ignored", longint'(txn_valid), 0);
            end
            rsp_valid = 1'b1; rsp_is_data = !w; rsp_line = ln;
            for (int j = 0; j < LINE_B; j++) rsp_data[j*8 +: 8] = mem_byte(int'(ln) + j);
            @(negedge clk);
            rsp_valid = 1'b0;
            chk("R8 matching response accepted", longint'(rsp_error), 0);
        end
        chk("R12 done pulse", longint'(done), 1);
        chk("R12 busy cleared", longint'(busy), 0);
        if (!w) begin
            nchk++;
            if (rd_buf !== exp_rd) begin
                nfail++;
                $display("FAIL R9: actual %h expected %h", rd_buf, exp_rd);
            end
        end
        chk("R11 scoreboard drained", longint'(exp_q.size()), 0);
        @(negedge clk);
        chk("R12 done one cycle", longint'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("reset busy", longint'(busy), 0);
        chk("reset done", longint'(done), 0);
        chk("reset txn_valid", longint'(txn_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_req(1'b0, 32'h103, 40, 0);   // R3 R4 R6 R9: three pieces 13/16/11
        do_req(1'b1, 32'h205, 7, 0);    // R5: fits strictly inside a line
        do_req(1'b1, 32'h30A, 6, 0);    // R4: ends exactly at line end
        do_req(1'b1, 32'h400, 64, 0);   // R7: four aligned full lines
        do_req(1'b0, 32'h510, 16, 0);   // R9: single aligned line
        do_req(1'b0, 32'h60F, 1, 0);    // R4: last byte of a line
        do_req(1'b0, 32'h700, 0, 0);    // R2
        do_req(1'b1, 32'h80C, 20, 1);   // R1: competing request
        do_req(1'b0, 32'h903, 30, 2);   // R8: wrong line response
        do_req(1'b1, 32'hA01, 18, 3);   // R10: data on a write
        do_req(1'b0, 32'hB07, 12, 3);   // R10: ack on a read
        // R10: response while idle
        @(negedge clk);
        rsp_valid = 1'b1; rsp_is_data = 1'b1; rsp_line = 32'h500;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk("R10 idle response error", longint'(rsp_error), 1);
        chk("R10 idle response no transaction", longint'(txn_valid), 0);
        // R1: oversize request
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'hC00; req_len = 7'd65;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 oversize rejected", longint'(req_reject), 1);
        chk("R1 oversize stays idle", longint'(busy), 0);
        chk("R1 oversize no transaction", longint'(txn_valid), 0);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule